// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes a word between two ports, A and B. Each direction has its own store: A-to-B and B-to-A. A store can pass its input straight through while it is open. It can also keep the last word it took in once it closes. Each direction has three active-low controls: a lane select, a capture gate and a drive gate. The lane select qualifies both capture and drive. When it is high, that direction takes in nothing and drives nothing, whatever the other two controls say. The two directions never share state, so each side can hold a different word at the same time.

Each port is split into an input value, an output value and a drive-enable flag, as in a pad interface inside a chip. The drive-enable tells the surrounding logic when the block owns the bus. The default store is a register that loads on each clock edge while it is open, so the capture gate acts as a load enable. A parameter selects a level-sensitive latch instead. The stores clear to zero on reset.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While `ab_sel_n`, `ab_cap_n` and `ab_drv_n` are all 0, `b_out` equals `a_in` bit for bit, without inversion, in the same cycle.
- R2: After `ab_cap_n` rises with `ab_sel_n` low, `b_out` shows the value `a_in` had at the last rising clock edge while the gate was open. It keeps that value while `a_in` changes.
- R3: `b_drive` is 1 exactly when `ab_sel_n` and `ab_drv_n` are both 0, and `a_drive` is 1 exactly when `ba_sel_n` and `ba_drv_n` are both 0. Each flag is combinational in its controls.
- R4: While `ab_sel_n` is 1, clock edges with `ab_cap_n` low leave the A-to-B store unchanged, and `b_drive` stays 0.
- R5: The B-to-A direction follows R1, R2 and R4, using `ba_sel_n`, `ba_cap_n` and `ba_drv_n`, with `b_in` as its input and `a_out` as its output.
- R6: Both stores can capture at the same clock edge with different words, and each then holds its own word.
- R7: After reset both stores hold 0. With a direction selected and driving but not capturing, its output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered store |
| rst_n | input | 1 | Active-low asynchronous reset, clears both stores |
| ab_sel_n | input | 1 | A-to-B lane select, active low |
| ab_cap_n | input | 1 | A-to-B capture gate, active low (open = pass/load) |
| ab_drv_n | input | 1 | A-to-B drive gate, active low |
| ba_sel_n | input | 1 | B-to-A lane select, active low |
| ba_cap_n | input | 1 | B-to-A capture gate, active low |
| ba_drv_n | input | 1 | B-to-A drive gate, active low |
| a_in | input | WIDTH | Value present on bus A |
| a_out | output | WIDTH | Value the block puts on bus A (0 when not driving) |
| a_drive | output | 1 | Block drives bus A |
| b_in | input | WIDTH | Value present on bus B |
| b_out | output | WIDTH | Value the block puts on bus B (0 when not driving) |
| b_drive | output | 1 | Block drives bus B |

## Verification
Both stores can load at the same clock edge. The bench opens both capture gates in one cycle, with distinct words on the two buses and both outputs off, and closes the gates together. It then turns both outputs on and expects each port to show the word taken from the opposite side. If the two lanes leaked into each other, one side would read back the wrong word. A monitor also flags any cycle in which the block drives a bus that the bench is driving, which keeps each step free of contention.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Active-low control group of one direction
  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic drv_n;
  } lane_ctl_t;

  // Store is open (passes / loads its input)
  function automatic logic lane_open(lane_ctl_t c);
    return !c.sel_n && !c.cap_n;
  endfunction

  // Direction owns its output bus
  function automatic logic lane_owns_bus(lane_ctl_t c);
    return !c.sel_n && !c.drv_n;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned WIDTH      = 8,
  parameter bit          SYNC_STORE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] view,
  output logic [WIDTH-1:0] held
);

  logic [WIDTH-1:0] word_q;

  generate
    if (SYNC_STORE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (open_en) word_q <= din;
      end
      // Open store shows the live input, closed store its kept word
      assign view = open_en ? din : word_q;

      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !open_en |=> $stable(held)); // R4
      AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |=> (held == $past(din))); // R2
    end else begin : g_lat
      always_latch begin
        if (!rst_n)       word_q = '0;
        else if (open_en) word_q = din;
      end
      assign view = word_q;
    end
  endgenerate

  assign held = word_q;

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xcvr_pkg::lane_ctl_t ctl,
  input  logic [WIDTH-1:0]    view,
  output logic [WIDTH-1:0]    dout,
  output logic                drive
);

  assign drive = xcvr_pkg::lane_owns_bus(ctl);
  assign dout  = drive ? view : '0;

  AST_DRIVE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.sel_n |-> !drive); // R3
  AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (dout == '0)); // R3

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned WIDTH      = 8,
  parameter bit          SYNC_STORE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xcvr_pkg::lane_ctl_t ctl,
  input  logic [WIDTH-1:0]    din,
  output logic [WIDTH-1:0]    dout,
  output logic                drive,
  output logic                open_en,
  output logic [WIDTH-1:0]    held
);

  logic [WIDTH-1:0] view;

  assign open_en = xcvr_pkg::lane_open(ctl);

  xcvr_store #(.WIDTH(WIDTH), .SYNC_STORE(SYNC_STORE)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_en (open_en),
    .din     (din),
    .view    (view),
    .held    (held)
  );

  xcvr_drive #(.WIDTH(WIDTH)) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .view  (view),
    .dout  (dout),
    .drive (drive)
  );

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
  parameter int unsigned WIDTH      = 8,
  parameter bit          SYNC_STORE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_sel_n,
  input  logic             ab_cap_n,
  input  logic             ab_drv_n,
  input  logic             ba_sel_n,
  input  logic             ba_cap_n,
  input  logic             ba_drv_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive
);

  localparam int unsigned NDIR = 2; // index 0: A to B, index 1: B to A

  xcvr_pkg::lane_ctl_t ctl     [NDIR];
  logic [WIDTH-1:0]    din     [NDIR];
  logic [WIDTH-1:0]    dout    [NDIR];
  logic [WIDTH-1:0]    held    [NDIR];
  logic                drive   [NDIR];
  logic                open_en [NDIR];

  assign ctl[0] = '{sel_n: ab_sel_n, cap_n: ab_cap_n, drv_n: ab_drv_n};
  assign ctl[1] = '{sel_n: ba_sel_n, cap_n: ba_cap_n, drv_n: ba_drv_n};
  assign din[0] = a_in;
  assign din[1] = b_in;

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      xcvr_lane #(.WIDTH(WIDTH), .SYNC_STORE(SYNC_STORE)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl[d]),
        .din     (din[d]),
        .dout    (dout[d]),
        .drive   (drive[d]),
        .open_en (open_en[d]),
        .held    (held[d])
      );
    end
  endgenerate

  assign b_out   = dout[0];
  assign b_drive = drive[0];
  assign a_out   = dout[1];
  assign a_drive = drive[1];

  AST_PASS_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_sel_n && !ab_cap_n && !ab_drv_n) |-> (b_out == a_in)); // R1
  AST_PASS_BA: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_sel_n && !ba_cap_n && !ba_drv_n) |-> (a_out == b_in)); // R5

  generate
    if (SYNC_STORE) begin : g_apart
      AST_LANES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (open_en[0] && !open_en[1]) |=> $stable(held[1])); // R6
    end
  endgenerate

endmodule

// File: tb/bidir_latch_xcvr_test.sv
module bidir_latch_xcvr_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ab_sel_n, ab_cap_n, ab_drv_n;
  logic         ba_sel_n, ba_cap_n, ba_drv_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drive, b_drive;
  logic         a_ext, b_ext;   // bench is driving that bus
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bidir_latch_xcvr #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .ab_sel_n(ab_sel_n), .ab_cap_n(ab_cap_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_cap_n(ba_cap_n), .ba_drv_n(ba_drv_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Contention monitor: block must not drive a bus the bench drives
  always @(posedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (a_drive && a_ext) begin
        n_chk++; n_bad++;
        $display("FAIL R3: contention on A actual %b expected 0", a_drive);
      end
      if (b_drive && b_ext) begin
        n_chk++; n_bad++;
        $display("FAIL R3: contention on B actual %b expected 0", b_drive);
      end
    end
  end

  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    to_neg();
    ab_sel_n = 0; ab_cap_n = 1; ab_drv_n = 0; b_ext = 0;
    ba_sel_n = 0; ba_cap_n = 1; ba_drv_n = 0; a_ext = 0;
    #1;
    check("R7 b_out", b_out, 8'h00);
    check("R7 a_out", a_out, 8'h00);
  endtask

  task automatic t_drive_flags();
    for (int c = 0; c < 4; c++) begin
      to_neg();
      a_ext = 0; b_ext = 0;
      ab_cap_n = 1; ba_cap_n = 1;
      ab_sel_n = c[1]; ab_drv_n = c[0];
      ba_sel_n = c[0]; ba_drv_n = c[1];
      #1;
      check("R3 b_drive", {7'd0, b_drive}, {7'd0, (c == 0)});
      check("R3 a_drive", {7'd0, a_drive}, {7'd0, (c == 0)});
    end
  endtask

  task automatic t_ab_pass_hold();
    to_neg();
    ba_sel_n = 1; ba_cap_n = 1; ba_drv_n = 1;
    a_ext = 1; b_ext = 0;
    ab_sel_n = 0; ab_cap_n = 0; ab_drv_n = 0;
    a_in = 8'hA5;
    #1 check("R1 pass A5", b_out, 8'hA5);
    a_in = 8'h3C;
    #1 check("R1 pass 3C", b_out, 8'h3C);
    tick();                        // edge loads 3C
    ab_cap_n = 1; a_in = 8'hC3;
    #1 check("R2 hold", b_out, 8'h3C);
    tick();
    check("R2 hold later", b_out, 8'h3C);
  endtask

  task automatic t_ab_deselect();
    to_neg();
    ab_sel_n = 1; ab_cap_n = 0; ab_drv_n = 0; a_in = 8'hFF;
    #1 check("R4 no drive", {7'd0, b_drive}, 8'h00);
    tick(); tick();
    ab_sel_n = 0; ab_cap_n = 1;
    #1 check("R4 store unchanged", b_out, 8'h3C);
  endtask

  task automatic t_ba_pass_hold();
    to_neg();
    ab_drv_n = 1; ab_cap_n = 1;
    b_ext = 1; a_ext = 0;
    ba_sel_n = 0; ba_cap_n = 0; ba_drv_n = 0;
    b_in = 8'h69;
    #1 check("R5 pass", a_out, 8'h69);
    tick();
    ba_cap_n = 1; b_in = 8'h96;
    #1 check("R5 hold", a_out, 8'h69);
    ba_sel_n = 1; ba_cap_n = 0;
    tick(); tick();
    ba_sel_n = 0; ba_cap_n = 1;
    #1 check("R5 deselect keeps", a_out, 8'h69);
  endtask

  task automatic t_dual_capture();
    to_neg();
    ab_drv_n = 1; ba_drv_n = 1;
    ab_sel_n = 0; ba_sel_n = 0;
    a_ext = 1; b_ext = 1;
    ab_cap_n = 0; ba_cap_n = 0;
    a_in = 8'h11; b_in = 8'hEE;
    tick();                        // both load at one edge
    ab_cap_n = 1; ba_cap_n = 1;
    a_ext = 0; b_ext = 0;
    a_in = 8'h00; b_in = 8'h00;
    ab_drv_n = 0; ba_drv_n = 0;
    #1;
    check("R6 b side", b_out, 8'h11);
    check("R6 a side", a_out, 8'hEE);
    tick();
    check("R6 b side later", b_out, 8'h11);
    check("R6 a side later", a_out, 8'hEE);
  endtask

  initial begin
    rst_n = 0; a_ext = 0; b_ext = 0;
    ab_sel_n = 1; ab_cap_n = 1; ab_drv_n = 1;
    ba_sel_n = 1; ba_cap_n = 1; ba_drv_n = 1;
    a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_drive_flags();
    t_ab_pass_hold();
    t_ab_deselect();
    t_ba_pass_hold();
    t_dual_capture();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule